// File: doc/BRIEF.md
# Serial Register Programming Port

This block is the slave end of a synchronous serial link through which a host programs a small bank of configuration registers. Every transfer opens with an 8-bit instruction that names a register and a direction. It is followed by a data phase whose length in bits is eight times the byte width of that register.

The host's serial clock, chip select, data lines and abort strobe are all brought into the block's own clock domain and treated as sampled levels. Running the block at ten times the serial clock rate or faster leaves ample margin.

The transfer order is set by a control register and can be changed at run time. The same order also governs how the instruction is shifted in. Read data leaves either on the shared data line (3-wire use) or on a dedicated output (4-wire use). Raising chip select freezes a transfer where it stands, and the abort strobe discards it.

Top module: `cfg_serial_port`

## Requirements
- R1: Instruction bit 7 set to 1 makes the data phase a read, driven out by the block; set to 0 it makes a write, and during a write neither output enable is asserted.
- R2: Instruction bits 4..0 select the register; bits 6 and 5 have no effect on which register is accessed.
- R3: Register widths are 4 bytes at address 0, 3 bytes at address 1, 2 bytes at address 2 and 1 byte at address 3. Any other address uses a 1-byte data phase, reads as zero and leaves every register unchanged when written.
- R4: With control bit 8 at 0, a value moves most significant bit first across the whole register, so the top byte comes first and each byte goes MSB first. The instruction also goes MSB first.
- R5: With control bit 8 at 1, the instruction and the data move least significant bit first, so instruction 0x02 appears on the wire as 0x40 sent MSB first.
- R6: With control bit 9 at 0, read data is driven on sdio_out with sdio_oe high and sdo_oe low. With bit 9 at 1, sdio is input only and read data goes out on sdo with sdo_oe high and sdio_oe low.
- R7: While cs_n is high both output enables are low and serial clock edges are ignored. A transfer interrupted by cs_n resumes at the same bit once cs_n falls again.
- R8: A high level on iosync abandons the current transfer without changing any register, and the next bit the host sends is taken as the first bit of a new instruction.
- R9: A write updates its register only when the final data bit has been received; a write cut short changes nothing.
- R10: Data is sampled on the serial clock's rising edge, and read bits are changed on its falling edge, so each read bit is stable at the following rising edge.
- R11: After reset every register reads zero, the port expects an instruction, and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, at least ten times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data line, input side |
| sdio_out | output | 1 | Serial data line, output side |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo | output | 1 | Dedicated serial data output |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| iosync | input | 1 | Active-high transfer abort |

## Verification
The assertions assume that the host holds each serial clock phase for several block clocks, and that it changes cs_n, iosync and data only while sclk is low. Under those conditions a sampled edge never coincides with a change of chip select or abort, and the pause and abort checks hold. The stimulus keeps every sclk half period at five block clocks. It moves data one half period ahead of each rising edge, and raises or lowers cs_n and iosync only between bits, with sclk low, holding each for four or more clocks.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  parameter int ADDR_W   = 5;
  parameter int DATA_MAX = 32;
  parameter int NUM_REGS = 4;
  parameter int SYNC_STG = 2;
  parameter int ORDER_BIT = 8;
  parameter int MODE_BIT  = 9;

  localparam int CNT_W = $clog2(DATA_MAX) + 1;
  localparam int IDX_W = $clog2(DATA_MAX);

  typedef enum logic {ST_INSTR = 1'b0, ST_DATA = 1'b1} port_state_e;

  function automatic int unsigned reg_bytes(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0:    return 4;
      5'd1:    return 3;
      5'd2:    return 2;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_n_s = pipe_q[1];
endmodule

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
  parameter int STAGES = cfg_port_pkg::SYNC_STG
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdio,
  input  logic iosync,
  output logic s_cs_n,
  output logic s_sdio,
  output logic s_iosync,
  output logic sclk_rise,
  output logic sclk_fall
);
  localparam int NSIG = 4;
  localparam logic [NSIG-1:0] RST_VAL = 4'b0010; // {iosync, sdio, cs_n, sclk}

  logic [NSIG-1:0] stg_q [STAGES];
  logic            sclk_prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [NSIG-1:0] d;
    if (s == 0) begin : g_first
      assign d = {iosync, sdio, cs_n, sclk};
    end else begin : g_next
      assign d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= stg_q[STAGES-1][0];
  end

  assign s_cs_n    = stg_q[STAGES-1][1];
  assign s_sdio    = stg_q[STAGES-1][2];
  assign s_iosync  = stg_q[STAGES-1][3];
  assign sclk_rise = stg_q[STAGES-1][0] & ~sclk_prev_q;
  assign sclk_fall = ~stg_q[STAGES-1][0] & sclk_prev_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_MAX-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_MAX-1:0] rd_data,
  output logic                ctrl_lsb,
  output logic                ctrl_sdio_in
);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_MAX-1:0] rd_vec [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int W = 8 * reg_bytes(ADDR_W'(i));
    logic [W-1:0] q;
    logic         hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data[W-1:0];
    end
    assign rd_vec[i] = DATA_MAX'(q);
  end

  always_comb begin
    if (rd_addr < ADDR_W'(NUM_REGS)) rd_data = rd_vec[rd_addr[SEL_W-1:0]];
    else                             rd_data = '0;
  end

  assign ctrl_lsb     = rd_vec[0][ORDER_BIT];
  assign ctrl_sdio_in = rd_vec[0][MODE_BIT];
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo,
  output logic sdo_oe,
  input  logic iosync
);
  logic rst_n_s;
  logic s_cs_n, s_sdio, s_iosync, sclk_rise, sclk_fall;
  logic rise_en, fall_en;

  port_state_e         st_q, st_d;
  logic [CNT_W-1:0]    bit_cnt_q, bit_cnt_d;
  logic [7:0]          instr_q, instr_d, instr_nxt;
  logic                rw_q, rw_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_MAX-1:0] dsh_q, dsh_d, dsh_nxt;
  logic [DATA_MAX-1:0] rdw_q, rdw_d;
  logic                out_q, out_d;

  logic                wr_en;
  logic [DATA_MAX-1:0] wr_data, bank_rd;
  logic                ctrl_lsb, ctrl_sdio_in;
  logic [CNT_W-1:0]    nbits;
  logic [IDX_W-1:0]    rd_idx;
  logic                rd_drive;

  cfg_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  cfg_edge_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sdio      (sdio_in),
    .iosync    (iosync),
    .s_cs_n    (s_cs_n),
    .s_sdio    (s_sdio),
    .s_iosync  (s_iosync),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  cfg_reg_bank u_bank (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .wr_en        (wr_en),
    .wr_addr      (addr_q),
    .wr_data      (wr_data),
    .rd_addr      (instr_nxt[ADDR_W-1:0]),
    .rd_data      (bank_rd),
    .ctrl_lsb     (ctrl_lsb),
    .ctrl_sdio_in (ctrl_sdio_in)
  );

  assign rise_en = sclk_rise & ~s_cs_n & ~s_iosync;
  assign fall_en = sclk_fall & ~s_cs_n & ~s_iosync;
  assign nbits   = CNT_W'(8 * reg_bytes(addr_q));

  // shift paths for both transfer orders
  assign instr_nxt = ctrl_lsb ? {s_sdio, instr_q[7:1]} : {instr_q[6:0], s_sdio};
  assign dsh_nxt   = ctrl_lsb ? {s_sdio, dsh_q[DATA_MAX-1:1]} : {dsh_q[DATA_MAX-2:0], s_sdio};
  assign wr_data   = ctrl_lsb ? (dsh_nxt >> (CNT_W'(DATA_MAX) - nbits)) : dsh_nxt;
  assign rd_idx    = ctrl_lsb ? bit_cnt_q[IDX_W-1:0]
                              : IDX_W'(nbits - CNT_W'(1) - bit_cnt_q);

  always_comb begin
    st_d      = st_q;
    bit_cnt_d = bit_cnt_q;
    instr_d   = instr_q;
    rw_d      = rw_q;
    addr_d    = addr_q;
    dsh_d     = dsh_q;
    rdw_d     = rdw_q;
    out_d     = out_q;
    wr_en     = 1'b0;
    if (s_iosync) begin
      st_d      = ST_INSTR;
      bit_cnt_d = '0;
    end else if (rise_en) begin
      case (st_q)
        ST_INSTR: begin
          instr_d = instr_nxt;
          if (bit_cnt_q == CNT_W'(7)) begin
            st_d      = ST_DATA;
            bit_cnt_d = '0;
            rw_d      = instr_nxt[7];
            addr_d    = instr_nxt[ADDR_W-1:0];
            rdw_d     = bank_rd;
          end else begin
            bit_cnt_d = bit_cnt_q + CNT_W'(1);
          end
        end
        default: begin
          dsh_d = dsh_nxt;
          if (bit_cnt_q == nbits - CNT_W'(1)) begin
            st_d      = ST_INSTR;
            bit_cnt_d = '0;
            wr_en     = ~rw_q;
          end else begin
            bit_cnt_d = bit_cnt_q + CNT_W'(1);
          end
        end
      endcase
    end else if (fall_en && st_q == ST_DATA && rw_q) begin
      out_d = rdw_q[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q      <= ST_INSTR;
      bit_cnt_q <= '0;
      instr_q   <= '0;
      rw_q      <= 1'b0;
      addr_q    <= '0;
      dsh_q     <= '0;
      rdw_q     <= '0;
      out_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      bit_cnt_q <= bit_cnt_d;
      instr_q   <= instr_d;
      rw_q      <= rw_d;
      addr_q    <= addr_d;
      dsh_q     <= dsh_d;
      rdw_q     <= rdw_d;
      out_q     <= out_d;
    end
  end

  assign rd_drive = (st_q == ST_DATA) && rw_q && ~cs_n;
  assign sdio_oe  = rd_drive & ~ctrl_sdio_in;
  assign sdo_oe   = rd_drive & ctrl_sdio_in;
  assign sdio_out = out_q;
  assign sdo      = out_q;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfg_port_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sdio_oe,
  input logic             sdo_oe,
  input logic             s_cs_n,
  input logic             s_iosync,
  input port_state_e      st_q,
  input logic [CNT_W-1:0] bit_cnt_q,
  input logic             wr_en,
  input logic             rw_q,
  input logic             ctrl_sdio_in
);
  // R8
  iosync_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_iosync |=> (st_q == ST_INSTR && bit_cnt_q == '0));

  // R7
  cs_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs_n && !s_iosync) |=> ($stable(bit_cnt_q) && $stable(st_q)));

  // R7
  cs_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sdio_oe && !sdo_oe));

  // R6
  oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdio_oe && sdo_oe));

  // R6
  sdo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> ctrl_sdio_in);

  // R1
  read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe || sdo_oe) |-> rw_q);

  // R9
  wr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (st_q == ST_DATA && !rw_q));

  // R9
  wr_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (st_q == ST_INSTR && bit_cnt_q == '0));
endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .sdio_oe      (sdio_oe),
  .sdo_oe       (sdo_oe),
  .s_cs_n       (s_cs_n),
  .s_iosync     (s_iosync),
  .st_q         (st_q),
  .bit_cnt_q    (bit_cnt_q),
  .wr_en        (wr_en),
  .rw_q         (rw_q),
  .ctrl_sdio_in (ctrl_sdio_in)
);

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
  logic clk, rst_n, sclk, cs_n, sdio_in, iosync;
  logic sdio_out, sdio_oe, sdo, sdo_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] model [4];

  cfg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .sdo(sdo), .sdo_oe(sdo_oe), .iosync(iosync)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int nbits_of(input logic [4:0] a);
    case (a)
      5'd0: return 32;
      5'd1: return 24;
      5'd2: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    return (a < 5'd4) ? (model[a[1:0]] & mask_of(nbits_of(a))) : 32'd0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one serial bit: data set with sclk low, sampled just before the rise
  task automatic bit_xfer(input logic b, output logic r, output logic oe_io,
                          output logic oe_so);
    @(negedge clk);
    sdio_in = b;
    repeat (4) @(negedge clk);
    r     = model[0][9] ? sdo : sdio_out;
    oe_io = sdio_oe;
    oe_so = sdo_oe;
    sclk = 1'b1;
    repeat (5) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic pulse_abort();
    repeat (2) @(negedge clk);
    iosync = 1'b1;
    repeat (6) @(negedge clk);
    iosync = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // full transfer; pause_at / abort_at index data bits (-1 = none)
  task automatic run_cycle(input logic [7:0] ib, input logic [31:0] wd,
                           input int pause_at, input int abort_at,
                           output logic [31:0] rdat);
    bit lsb = model[0][8];
    bit rd  = ib[7];
    logic [4:0] a = ib[4:0];
    int n = nbits_of(a);
    logic r, oi, os;
    bit oe_ok = 1;
    rdat = '0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      bit_xfer(lsb ? ib[i] : ib[7-i], r, oi, os);
      if (oi || os) oe_ok = 0;
    end
    for (int k = 0; k < n; k++) begin
      int idx = lsb ? k : n - 1 - k;
      if (k == abort_at) begin
        pulse_abort();
        check(oe_ok, "R1 oe during partial", {30'd0, oi, os}, 32'd0);
        return;
      end
      if (k == pause_at) begin
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!sdio_oe && !sdo_oe, "R7 hi-z while deselected",
              {30'd0, sdio_oe, sdo_oe}, 32'd0);
        for (int j = 0; j < 3; j++) begin
          sdio_in = 1'($urandom);
          sclk = 1'b1; repeat (5) @(negedge clk);
          sclk = 1'b0; repeat (5) @(negedge clk);
        end
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
      end
      bit_xfer(wd[idx], r, oi, os);
      rdat[idx] = r;
      if (rd) begin
        if (model[0][9] ? (!os || oi) : (!oi || os)) oe_ok = 0;
      end else if (oi || os) oe_ok = 0;
    end
    check(oe_ok, rd ? "R6 read pin enables" : "R1 no drive during write",
          {31'd0, oe_ok}, 32'd1);
    if (!rd && a < 5'd4) model[a[1:0]] = wd & mask_of(n);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] ib, input logic [31:0] d);
    logic [31:0] dummy;
    run_cycle({1'b0, ib[6:0]}, d, -1, -1, dummy);
  endtask

  task automatic rd_chk(input logic [7:0] ib, input string req);
    logic [31:0] got, exp;
    exp = exp_read(ib[4:0]);
    run_cycle({1'b1, ib[6:0]}, 32'd0, -1, -1, got);
    check(got == exp, req, got, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, exp;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) model[i] = '0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdio_in = 1'b0; iosync = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    check(!sdio_oe && !sdo_oe, "R11 enables after reset", {30'd0, sdio_oe, sdo_oe}, 32'd0);
    for (int a = 0; a < 4; a++) rd_chk(8'(a), "R11 reset value");

    // R4 MSB-first writes and reads, R3 widths
    wr(8'h02, 32'h0000_BEEF);  rd_chk(8'h02, "R4 msb-first reg2");
    wr(8'h01, 32'hFFA5_C37E);  rd_chk(8'h01, "R3 24-bit reg1");
    wr(8'h03, 32'hFFFF_FF5A);  rd_chk(8'h03, "R3 8-bit reg3");
    wr(8'h00, 32'h1234_00FF);  rd_chk(8'h00, "R4 msb-first reg0");

    // R2 bits 6..5 ignored
    rd_chk(8'h62, "R2 don't-care bits read");
    wr(8'h21, 32'h0013_579B);  rd_chk(8'h41, "R2 don't-care bits write");

    // R3 unmapped address
    wr(8'h07, 32'h0000_00FF);
    rd_chk(8'h07, "R3 unmapped reads zero");
    rd_chk(8'h03, "R3 unmapped write leaves reg3");
    rd_chk(8'h00, "R3 unmapped write leaves reg0");

    // R1 read does not modify
    rd_chk(8'h82, "R1 read path");
    rd_chk(8'h02, "R1 read left reg2 intact");

    // R6 4-wire mode via control bit 9
    wr(8'h00, 32'h0000_0200);
    rd_chk(8'h02, "R6 read on sdo");
    rd_chk(8'h00, "R6 control readback on sdo");
    wr(8'h00, 32'h0000_0000);
    rd_chk(8'h01, "R6 back to shared line");

    // R5 LSB-first via control bit 8; instruction 0x02 sent bit0 first (0x40 on wire)
    wr(8'h00, 32'h0000_0100);
    wr(8'h02, 32'h0000_1234);
    rd_chk(8'h02, "R5 lsb-first reg2");
    wr(8'h01, 32'h00AB_CDEF);
    rd_chk(8'h01, "R5 lsb-first reg1");
    rd_chk(8'h00, "R5 lsb-first control");
    wr(8'h00, 32'h0000_0000);
    rd_chk(8'h02, "R5 back to msb-first");

    // R7 pause and resume on write and read
    run_cycle(8'h01, 32'h0055_AA33, 10, -1, got);
    rd_chk(8'h01, "R7 resumed write");
    exp = exp_read(5'd0);
    run_cycle(8'h80, 32'd0, 13, -1, got);
    check(got == exp, "R7 resumed read", got, exp);

    // R8 / R9 abort mid-write and mid-instruction
    run_cycle(8'h02, 32'h0000_0F0F, -1, 9, got);
    rd_chk(8'h02, "R9 aborted write ignored");
    run_cycle(8'h01, 32'h0000_0001, -1, 0, got);
    rd_chk(8'h01, "R8 abort at data start");
    cs_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      logic r, oi, os;
      bit_xfer(1'b1, r, oi, os);
    end
    pulse_abort();
    rd_chk(8'h03, "R8 abort inside instruction");

    // R10 timing via random mix of orders, modes and addresses
    for (int t = 0; t < 60; t++) begin
      logic [7:0] ib;
      logic [31:0] d;
      ib = {1'b0, 2'($urandom), 5'($urandom_range(0, 7))};
      d  = $urandom;
      if (ib[4:0] == 5'd0) d[31:10] = 22'($urandom);
      if ($urandom_range(0, 2) == 0) rd_chk(ib, "R10 random read");
      else wr(ib, d);
    end
    for (int a = 0; a < 5; a++) rd_chk(8'(a), "R10 final readback");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule